// File: doc/BRIEF.md
# Serial Control Register Interface

This block is the host-facing write port of a radio baseband device. A host drives three pins: a serial clock, a frame-enable line, and a serial data line. While the frame-enable line is high, the block shifts in an 11-bit frame on each rising serial clock edge. The frame holds a 3-bit register address and then 8 data bits, most significant bit first. When the frame-enable line falls, the block commits the frame to one of eight 8-bit configuration registers. This happens only if exactly 11 bits arrived. All pin inputs are first synchronised into the system clock domain.

Each register has its own reset value. The reset values are loaded by the synchronous power-on reset or by a low level on an external reset pin. The test register is writable only while a strap pin is held high. A hardware frame-detect hook can hold the frame-detect disable bit at 1 while masking host writes to that single bit. The block decodes the operating mode from the top three bits of the first control register. It also decodes the emphasis and scrambler enables from two bits of the second control register.

Top module: `ctl_serial_regs`

## Requirements
- R1: After `rst`, the registers read: addr0 = 0x1F, addr1 = 0x3C, addr2 = 0x04, addr3 = 0x30, addr4 = 0x44, addr5 = 0x46, addr6 = 0x1B, addr7 = 0xFF.
- R2: While `dir` is high, `sdi` is sampled on each `sclk` rising edge. Bits 10..8 of the frame are the address and bits 7..0 are the data, first bit = bit 10. The addressed register changes only after `dir` falls; it is unchanged while `dir` is still high.
- R3: A frame whose count of `sclk` rising edges while `dir` is high is not exactly 11 changes no register.
- R4: Bits that a register does not implement always read 0, and writes to them are ignored. The used bits are 7..0 for addr 0, 5..0 for addr 1, 2..0 for addr 2, 5..0 for addr 3, 6..0 for addr 4, and 7..0 for addr 5, 6 and 7.
- R5: A write to address 7 takes effect only if `test_en` is high when the frame commits; otherwise that register keeps its value.
- R6: While `fd_active` is high, bit 0 of addr 1 is forced to 1. A host write to addr 1 in that time leaves bit 0 at 1 but applies bits 5..1.
- R7: `mode_o` decodes bits 7..5 of addr 0: 000→0, 001→1, 010→2, 011→3, and 1xx→4.
- R8: With em = addr1 bit 4 and pcont = addr1 bit 3: em=1 and pcont=1 gives `emph_en_o`=1 and `scram_en_o`=0. pcont=0 gives `scram_en_o`=1 and `emph_en_o`=0. em=0 and pcont=1 gives both 0.
- R9: Holding `cfg_rst_n` low for at least 4 clocks reloads every register with its R1 value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| cfg_rst_n | input | 1 | Asynchronous active-low register reset pin (synchronised) |
| sclk | input | 1 | Serial clock from host |
| dir | input | 1 | Frame enable; high during a write frame |
| sdi | input | 1 | Serial data from host |
| test_en | input | 1 | Strap that unlocks writes to the test register |
| fd_active | input | 1 | Frame-detect hook from the modem receive path |
| ctrl1_o | output | 8 | Register addr 0 |
| ctrl2_o | output | 8 | Register addr 1 |
| vol1_o | output | 8 | Register addr 2 |
| vol2_o | output | 8 | Register addr 3 |
| vol3_o | output | 8 | Register addr 4 |
| pat_lo_o | output | 8 | Register addr 5 |
| pat_hi_o | output | 8 | Register addr 6 |
| test_o | output | 8 | Register addr 7 |
| mode_o | output | 3 | Decoded operating mode 0..4 |
| emph_en_o | output | 1 | Emphasis enable |
| scram_en_o | output | 1 | Scrambler enable |

## Verification
A pin edge reaches the logic after a two-stage synchroniser and an edge-detect register. The commit pulse is registered, and the register updates on the following edge. A write is therefore visible about four clocks after `dir` falls. The bench waits six clocks after lowering `dir` and samples on the falling clock edge. The pin reset also passes through the synchroniser, so the bench checks it six clocks after release. The `fd_active` forcing is checked two clocks after it rises. The mode and enable outputs are combinational from the registers and are checked together with them.

// File: rtl/ctl_serial_pkg.sv
package ctl_serial_pkg;
    localparam int NUM_REGS  = 8;
    localparam int REG_W     = 8;
    localparam int ADDR_W    = $clog2(NUM_REGS);
    localparam int FRAME_LEN = ADDR_W + REG_W;
    localparam int CNT_W     = $clog2(FRAME_LEN + 2);

    localparam int ADDR_CTRL1 = 0;
    localparam int ADDR_CTRL2 = 1;
    localparam int ADDR_TEST  = 7;
    localparam int FCLN_BIT   = 0;
    localparam int EM_BIT     = 4;
    localparam int PCONT_BIT  = 3;

    typedef enum logic [2:0] {
        MODE_OFF   = 3'd0,
        MODE_OSC   = 3'd1,
        MODE_AUDIO = 3'd2,
        MODE_MODEM = 3'd3,
        MODE_FULL  = 3'd4
    } op_mode_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [REG_W-1:0]  data;
    } wr_frame_t;

    function automatic logic [REG_W-1:0] reg_reset(input int idx);
        case (idx)
            0:       return 8'h1F;
            1:       return 8'h3C;
            2:       return 8'h04;
            3:       return 8'h30;
            4:       return 8'h44;
            5:       return 8'h46;
            6:       return 8'h1B;
            default: return 8'hFF;
        endcase
    endfunction

    function automatic logic [REG_W-1:0] reg_mask(input int idx);
        case (idx)
            1, 3:    return 8'h3F;
            2:       return 8'h07;
            4:       return 8'h7F;
            default: return 8'hFF;
        endcase
    endfunction

    function automatic op_mode_e decode_mode(input logic [2:0] bs);
        if (bs[2]) return MODE_FULL;
        case (bs[1:0])
            2'b00:   return MODE_OFF;
            2'b01:   return MODE_OSC;
            2'b10:   return MODE_AUDIO;
            default: return MODE_MODEM;
        endcase
    endfunction
endpackage

// File: rtl/ctl_sync.sv
module ctl_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{RST_VAL}};
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/ctl_frame_rx.sv
module ctl_frame_rx
    import ctl_serial_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      sclk_s,
    input  logic      dir_s,
    input  logic      sdi_s,
    output logic      commit,
    output wr_frame_t frame
);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_LEN);
    localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(FRAME_LEN + 1);

    logic                 sclk_q, dir_q;
    logic [CNT_W-1:0]     cnt;
    logic [FRAME_LEN-1:0] shreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q <= 1'b0;
            dir_q  <= 1'b0;
            cnt    <= '0;
            shreg  <= '0;
            commit <= 1'b0;
        end else begin
            sclk_q <= sclk_s;
            dir_q  <= dir_s;
            commit <= 1'b0;
            if (dir_s && !dir_q) begin
                cnt <= '0;
            end else if (dir_s && sclk_s && !sclk_q) begin
                shreg <= {shreg[FRAME_LEN-2:0], sdi_s};
                if (cnt != CNT_OVER) cnt <= cnt + 1'b1;
            end
            if (!dir_s && dir_q) commit <= (cnt == CNT_FULL);
        end
    end

    assign frame = wr_frame_t'(shreg);

    // R3: a new frame always starts counting from zero
    p_cnt_clear_r3: assert property (@(posedge clk) disable iff (rst)
        (dir_s && !dir_q) |=> (cnt == '0));

    // R2: commit is a single-cycle strobe
    p_commit_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        commit |=> !commit);
endmodule

// File: rtl/ctl_reg_bank.sv
module ctl_reg_bank
    import ctl_serial_pkg::*;
(
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             commit,
    input  wr_frame_t                        frame,
    input  logic                             test_en,
    input  logic                             fd_active,
    output logic [NUM_REGS-1:0][REG_W-1:0]   regs
);
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        localparam logic [REG_W-1:0] RST_V = reg_reset(g);
        localparam logic [REG_W-1:0] MASK  = reg_mask(g);
        localparam bit IS_TEST  = (g == ADDR_TEST);
        localparam bit IS_CTRL2 = (g == ADDR_CTRL2);

        logic             hit;
        logic [REG_W-1:0] wmask;

        always_comb begin
            hit   = commit && (frame.addr == ADDR_W'(g)) && (!IS_TEST || test_en);
            wmask = MASK;
            if (IS_CTRL2 && fd_active) wmask[FCLN_BIT] = 1'b0;
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                regs[g] <= RST_V;
            end else begin
                if (hit) regs[g] <= (frame.data & wmask) | (regs[g] & ~wmask);
                if (IS_CTRL2 && fd_active) regs[g][FCLN_BIT] <= 1'b1;
            end
        end

        // R2: no change without a committed frame (or the hardware hook)
        p_hold_r2: assert property (@(posedge clk) disable iff (rst)
            (!commit && !fd_active) |=> $stable(regs[g]));

        if (IS_TEST) begin : g_test_chk
            // R5: locked while the strap is low
            p_test_lock_r5: assert property (@(posedge clk) disable iff (rst)
                !test_en |=> $stable(regs[g]));
        end

        if (IS_CTRL2) begin : g_fd_chk
            // R6: hook holds the disable bit
            p_fcln_hold_r6: assert property (@(posedge clk) disable iff (rst)
                fd_active |=> regs[g][FCLN_BIT]);
        end
    end
endmodule

// File: rtl/ctl_serial_regs.sv
module ctl_serial_regs
    import ctl_serial_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cfg_rst_n,
    input  logic       sclk,
    input  logic       dir,
    input  logic       sdi,
    input  logic       test_en,
    input  logic       fd_active,
    output logic [7:0] ctrl1_o,
    output logic [7:0] ctrl2_o,
    output logic [7:0] vol1_o,
    output logic [7:0] vol2_o,
    output logic [7:0] vol3_o,
    output logic [7:0] pat_lo_o,
    output logic [7:0] pat_hi_o,
    output logic [7:0] test_o,
    output logic [2:0] mode_o,
    output logic       emph_en_o,
    output logic       scram_en_o
);
    logic sclk_s, dir_s, sdi_s, rst_n_s, bank_rst, commit;
    wr_frame_t frame;
    logic [NUM_REGS-1:0][REG_W-1:0] regs;
    op_mode_e mode;

    ctl_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sclk (.clk(clk), .rst(rst), .d(sclk),      .q(sclk_s));
    ctl_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_dir  (.clk(clk), .rst(rst), .d(dir),       .q(dir_s));
    ctl_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sdi  (.clk(clk), .rst(rst), .d(sdi),       .q(sdi_s));
    ctl_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_rstn (.clk(clk), .rst(rst), .d(cfg_rst_n), .q(rst_n_s));

    assign bank_rst = rst || !rst_n_s;

    ctl_frame_rx u_rx (
        .clk(clk), .rst(bank_rst), .sclk_s(sclk_s), .dir_s(dir_s), .sdi_s(sdi_s),
        .commit(commit), .frame(frame)
    );

    ctl_reg_bank u_bank (
        .clk(clk), .rst(bank_rst), .commit(commit), .frame(frame),
        .test_en(test_en), .fd_active(fd_active), .regs(regs)
    );

    assign ctrl1_o  = regs[0];
    assign ctrl2_o  = regs[1];
    assign vol1_o   = regs[2];
    assign vol2_o   = regs[3];
    assign vol3_o   = regs[4];
    assign pat_lo_o = regs[5];
    assign pat_hi_o = regs[6];
    assign test_o   = regs[7];

    assign mode       = decode_mode(regs[ADDR_CTRL1][7:5]);
    assign mode_o     = mode;
    assign emph_en_o  = regs[ADDR_CTRL2][EM_BIT] && regs[ADDR_CTRL2][PCONT_BIT];
    assign scram_en_o = !regs[ADDR_CTRL2][PCONT_BIT];

    // R7: top mode bit dominates
    p_mode_full_r7: assert property (@(posedge clk) disable iff (bank_rst)
        ctrl1_o[7] |-> (mode_o == 3'd4));

    // R8: emphasis and scrambler never both on
    p_path_excl_r8: assert property (@(posedge clk) disable iff (bank_rst)
        !(emph_en_o && scram_en_o));
endmodule

// File: tb/ctl_serial_regs_tb.sv
module ctl_serial_regs_tb;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst = 1'b1, cfg_rst_n = 1'b1, sclk = 1'b0, dir = 1'b0, sdi = 1'b0;
    logic test_en = 1'b0, fd_active = 1'b0;
    logic [7:0] ctrl1_o, ctrl2_o, vol1_o, vol2_o, vol3_o, pat_lo_o, pat_hi_o, test_o;
    logic [2:0] mode_o;
    logic emph_en_o, scram_en_o;

    int n_tests = 0, n_fail = 0;
    bit done = 1'b0;
    logic [7:0] exp_r [8];

    always #(CLK_PERIOD/2) clk = ~clk;

    ctl_serial_regs u_dut (
        .clk(clk), .rst(rst), .cfg_rst_n(cfg_rst_n), .sclk(sclk), .dir(dir), .sdi(sdi),
        .test_en(test_en), .fd_active(fd_active),
        .ctrl1_o(ctrl1_o), .ctrl2_o(ctrl2_o), .vol1_o(vol1_o), .vol2_o(vol2_o),
        .vol3_o(vol3_o), .pat_lo_o(pat_lo_o), .pat_hi_o(pat_hi_o), .test_o(test_o),
        .mode_o(mode_o), .emph_en_o(emph_en_o), .scram_en_o(scram_en_o)
    );

    function automatic logic [7:0] rv(input int i);
        logic [7:0] t [8] = '{8'h1F, 8'h3C, 8'h04, 8'h30, 8'h44, 8'h46, 8'h1B, 8'hFF};
        return t[i];
    endfunction

    function automatic logic [7:0] mk(input int i);
        logic [7:0] t [8] = '{8'hFF, 8'h3F, 8'h07, 8'h3F, 8'h7F, 8'hFF, 8'hFF, 8'hFF};
        return t[i];
    endfunction

    function automatic logic [2:0] exp_mode(input logic [7:0] c1);
        if (c1[7]) return 3'd4;
        return {1'b0, c1[6:5]};
    endfunction

    function automatic logic [7:0] dut_reg(input int i);
        case (i)
            0: return ctrl1_o;   1: return ctrl2_o;  2: return vol1_o;   3: return vol2_o;
            4: return vol3_o;    5: return pat_lo_o; 6: return pat_hi_o; default: return test_o;
        endcase
    endfunction

    task automatic ticks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_regs(input string req);
        bit bad = 1'b0;
        n_tests++;
        for (int i = 0; i < 8; i++) begin
            if (dut_reg(i) !== exp_r[i]) begin
                $display("FAIL %s reg%0d actual=%02h expected=%02h", req, i, dut_reg(i), exp_r[i]);
                bad = 1'b1;
            end
        end
        if (mode_o !== exp_mode(exp_r[0])) begin
            $display("FAIL R7 (%s) mode actual=%0d expected=%0d", req, mode_o, exp_mode(exp_r[0]));
            bad = 1'b1;
        end
        if (emph_en_o !== (exp_r[1][4] & exp_r[1][3]) || scram_en_o !== ~exp_r[1][3]) begin
            $display("FAIL R8 (%s) emph/scram actual=%b%b expected=%b%b", req, emph_en_o, scram_en_o,
                     exp_r[1][4] & exp_r[1][3], ~exp_r[1][3]);
            bad = 1'b1;
        end
        if (bad) n_fail++;
    endtask

    // send nbits of {addr,data} MSB first (extra bits random); leave dir high if hold
    task automatic shift_bits(input logic [2:0] a, input logic [7:0] d, input int nbits);
        logic [10:0] w = {a, d};
        dir = 1'b1;
        ticks(4);
        for (int b = 0; b < nbits; b++) begin
            sdi = (b < 11) ? w[10-b] : 1'($urandom);
            ticks(3);
            sclk = 1'b1;
            ticks(3);
            sclk = 1'b0;
        end
        ticks(3);
    endtask

    task automatic end_frame();
        dir = 1'b0;
        ticks(6);
    endtask

    task automatic write_reg(input logic [2:0] a, input logic [7:0] d, input int nbits);
        shift_bits(a, d, nbits);
        end_frame();
        if (nbits == 11 && (a != 3'd7 || test_en)) begin
            exp_r[a] = d & mk(a);
            if (a == 3'd1 && fd_active) exp_r[1][0] = 1'b1;
        end
    endtask

    task automatic load_reset();
        for (int i = 0; i < 8; i++) exp_r[i] = rv(i);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        load_reset();
        ticks(5);
        rst = 1'b0;
        ticks(2);
        check_regs("R1");

        // R2: basic write, not visible before dir falls
        shift_bits(3'd2, 8'h05, 11);
        check_regs("R2 before dir fall");
        end_frame();
        exp_r[2] = 8'h05;
        check_regs("R2 after dir fall");

        // R2: MSB-first ordering with asymmetric pattern
        write_reg(3'd5, 8'hA1, 11);
        write_reg(3'd6, 8'h3C, 11);
        check_regs("R2 bit order");

        // R3: short and long frames discarded
        write_reg(3'd5, 8'h00, 10);
        write_reg(3'd6, 8'hFF, 12);
        write_reg(3'd0, 8'h00, 0);
        check_regs("R3");

        // R4: unused bits stay zero
        write_reg(3'd1, 8'hFF, 11);
        write_reg(3'd2, 8'hFF, 11);
        write_reg(3'd3, 8'hFF, 11);
        write_reg(3'd4, 8'hFF, 11);
        check_regs("R4");

        // R5: test register locked/unlocked
        test_en = 1'b0;
        write_reg(3'd7, 8'h12, 11);
        check_regs("R5 locked");
        test_en = 1'b1;
        write_reg(3'd7, 8'h34, 11);
        check_regs("R5 unlocked");
        test_en = 1'b0;

        // R6: hook forces fcln, write masks only that bit
        write_reg(3'd1, 8'h00, 11);
        fd_active = 1'b1;
        ticks(2);
        exp_r[1][0] = 1'b1;
        check_regs("R6 force");
        write_reg(3'd1, 8'h2A, 11);
        check_regs("R6 masked write");
        fd_active = 1'b0;
        ticks(2);
        write_reg(3'd1, 8'h00, 11);
        check_regs("R6 released");

        // R7: every mode code
        for (int m = 0; m < 8; m++) begin
            write_reg(3'd0, {3'(m), 5'h0A}, 11);
            check_regs("R7");
        end

        // R8: em/pcont combinations
        for (int c = 0; c < 4; c++) begin
            write_reg(3'd1, {3'b0, 2'(c), 3'b101}, 11);
            check_regs("R8");
        end

        // R9: pin reset
        cfg_rst_n = 1'b0;
        ticks(4);
        cfg_rst_n = 1'b1;
        ticks(6);
        load_reset();
        check_regs("R9");

        // random mix (R2 R3 R5)
        for (int k = 0; k < 40; k++) begin
            logic [2:0] a = 3'($urandom);
            logic [7:0] d = 8'($urandom);
            int n = (($urandom % 5) == 0) ? 8 + int'($urandom % 7) : 11;
            test_en = 1'($urandom);
            write_reg(a, d, n);
            check_regs("R2/R3/R5 random");
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule